// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block watches eight external interrupt pins. For each pin it raises a maskable interrupt request, and the kind of pin activity that counts is chosen per pin by a two-bit sense mode. The four modes are low level, any change, falling edge and rising edge.

Every raw pin first passes through a two-flop synchronizer that resets to one. The upper four pins (4 to 7) then go through one more sample register, and an edge on them is the difference between two successive samples. The lower four pins (0 to 3) form a faster group: their edge is taken straight from the synchronizer output, which removes one cycle of latency.

An edge or change event sets a sticky flag for its pin. The flag is cleared either by a write-one-to-clear strobe or by a per-pin acknowledge pulse. In low-level mode no flag is kept: the request follows the synchronized pin while the pin stays low. A pin's request reaches its output only when the pin's mask bit and the global enable are both set.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset, both mode registers, the mask register and all flags read 0, and `irq_o` is 0 while all pins are held high.
- R2: The sense-mode encoding is 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. `mode_hi_q` holds the mode of pin 4+k in bits 2k+1:2k, and `mode_lo_q` holds the mode of pin k in bits 2k+1:2k. Each register is loaded from its write data on a clock edge where its write enable is high, and reads back what was written.
- R3: Suppose a pin value is first sampled at rising edge k. For pins 4 to 7, the resulting edge event sets the flag at edge k+3. For pins 0 to 3 it sets the flag at edge k+2.
- R4: In falling-edge mode, only a 1-to-0 transition of the sampled pin sets the flag.
- R5: In rising-edge mode, only a 0-to-1 transition of the sampled pin sets the flag.
- R6: In any-change mode, both transitions set the flag. A pulse that lasts one clock sample sets it.
- R7: In low-level mode the flag is never set. The request is active exactly while the synchronized pin value is 0.
- R8: An edge event sets the flag even while the pin's mask bit or the global enable is clear.
- R9: On a clock edge with `flag_clr_we` high, each flag whose `flag_clr_data` bit is 1 clears, and flags whose data bit is 0 are unchanged.
- R10: An `ack_i` bit that is high on a clock edge clears that pin's flag.
- R11: When a set event and a clear (by write or by acknowledge) hit the same flag on the same edge, the flag ends up set.
- R12: `irq_o[i]` = `gie_i` AND `mask_q[i]` AND (flag i OR the level request of pin i). A flag that is already set appears on the output as soon as its pin is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Raw external interrupt pins |
| mode_lo_we | input | 1 | Write strobe for the mode register of pins 0 to 3 |
| mode_lo_wdata | input | 8 | Write data for the mode register of pins 0 to 3 |
| mode_hi_we | input | 1 | Write strobe for the mode register of pins 4 to 7 |
| mode_hi_wdata | input | 8 | Write data for the mode register of pins 4 to 7 |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 8 | Write data for the enable mask |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for the flags |
| flag_clr_data | input | 8 | Flags to clear, one bit per pin |
| ack_i | input | 8 | Per-pin acknowledge pulse that clears the flag |
| gie_i | input | 1 | Global interrupt enable |
| mode_lo_q | output | 8 | Mode register readback, pins 0 to 3 |
| mode_hi_q | output | 8 | Mode register readback, pins 4 to 7 |
| mask_q | output | 8 | Enable mask readback |
| flag_q | output | 8 | Sticky flags |
| irq_o | output | 8 | Gated interrupt requests |

## Verification
All four modes are assigned at once across the pins of each group, and then the modes are rotated, so that the same pin toggles are judged by every mode in both the fast group and the sampled group. Random toggling with frequent single-cycle pulses tells the any-change mode apart from the single-edge modes, and it exposes an off-by-one in group latency. Directed phases cover the other cases. Masked toggling separates flag setting from output gating. Clear and acknowledge are hit in the same cycle as an edge to test set priority. Holding level-mode pins low shows that the request tracks the pin without latching.

// File: rtl/eisc_pkg.sv
// Package: shared sense-mode type and event decode for the external
// interrupt sense controller. Assumes two bits of mode per pin.
package eisc_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;

    // Decide whether a sample pair forms an event under the given mode.
    function automatic logic edge_event(input sense_mode_e mode,
                                        input logic cur, input logic prv);
        logic ev;
        case (mode)
            SENSE_ANY:  ev = cur ^ prv;
            SENSE_FALL: ev = prv & ~cur;
            SENSE_RISE: ev = ~prv & cur;
            default:    ev = 1'b0;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/eisc_sync_sample.sv
// Module: synchronizes one raw pin and provides the current and previous
// samples used for edge detection. With SAMPLE_STAGE set, an extra sample
// register follows the synchronizer. All state resets to 1, so no false
// falling edge appears after reset. Assumes the pin is asynchronous to clk.
module eisc_sync_sample #(
    parameter int SYNC_STAGES  = 2,
    parameter bit SAMPLE_STAGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic cur,
    output logic prv
);

    logic [SYNC_STAGES-1:0] chain;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], pin_raw};
    end

    generate
        if (SAMPLE_STAGE) begin : g_sampled
            logic smp, smp_d;
            // Take a sample and keep the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    smp   <= 1'b1;
                    smp_d <= 1'b1;
                end else begin
                    smp   <= chain[SYNC_STAGES-1];
                    smp_d <= smp;
                end
            end
            assign cur = smp;
            assign prv = smp_d;
        end else begin : g_fast
            logic sync_d;
            // Keep the previous synchronized value for the fast path.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_d <= 1'b1;
                else        sync_d <= chain[SYNC_STAGES-1];
            end
            assign cur = chain[SYNC_STAGES-1];
            assign prv = sync_d;
        end
    endgenerate

    AST_PRV_FOLLOWS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prv == $past(cur)); // R3

endmodule

// File: rtl/eisc_flag_cell.sv
// Module: one pin's event decode and sticky flag. An event sets the flag.
// A clear request (write-one or acknowledge) resets it, but a same-cycle
// event wins. Also produces the level request. Assumes the mode is stable
// whenever the pin is enabled.
module eisc_flag_cell
    import eisc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sense_mode_e mode,
    input  logic        cur,
    input  logic        prv,
    input  logic        clr,
    output logic        flag,
    output logic        level_req
);

    logic ev;

    // Decode the event for the current sample pair.
    always_comb ev = edge_event(mode, cur, prv);

    // Level request: the pin is low while in low-level mode.
    always_comb level_req = (mode == SENSE_LOW) && !cur;

    // Sticky flag update, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (ev)  flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_EVENT_SETS:    assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> flag); // R11
    AST_CLEAR_WORKS:   assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev) |=> !flag); // R9
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW) |=> !$rose(flag)); // R7
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && !flag) |=> !flag); // R4

endmodule

// File: rtl/eisc_ctrl_regs.sv
// Module: the mode registers for both pin groups and the enable mask,
// each loaded whole on its write strobe. Assumes NUM_PINS is even.
module eisc_ctrl_regs #(
    parameter int NUM_PINS = 8,
    localparam int HALF    = NUM_PINS / 2,
    localparam int MW      = 2 * HALF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_lo_we,
    input  logic [MW-1:0]       mode_lo_wdata,
    input  logic                mode_hi_we,
    input  logic [MW-1:0]       mode_hi_wdata,
    input  logic                mask_we,
    input  logic [NUM_PINS-1:0] mask_wdata,
    output logic [MW-1:0]       mode_lo,
    output logic [MW-1:0]       mode_hi,
    output logic [NUM_PINS-1:0] mask
);

    // Mode register for the fast (lower) group.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_lo <= '0;
        else if (mode_lo_we) mode_lo <= mode_lo_wdata;
    end

    // Mode register for the sampled (upper) group.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_hi <= '0;
        else if (mode_hi_we) mode_hi <= mode_hi_wdata;
    end

    // Per-pin enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_hi_we |=> $stable(mode_hi)); // R2

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
// Module: top of the external interrupt sense controller. The lower half
// of the pins uses the fast path and the upper half adds a sample stage.
// Each pin has a sticky flag and a gated request. Assumes software clears
// a pin's mask bit before changing its mode.
module ext_irq_sense_ctrl
    import eisc_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int HALF       = NUM_PINS / 2,
    localparam int MW         = 2 * HALF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                mode_lo_we,
    input  logic [MW-1:0]       mode_lo_wdata,
    input  logic                mode_hi_we,
    input  logic [MW-1:0]       mode_hi_wdata,
    input  logic                mask_we,
    input  logic [NUM_PINS-1:0] mask_wdata,
    input  logic                flag_clr_we,
    input  logic [NUM_PINS-1:0] flag_clr_data,
    input  logic [NUM_PINS-1:0] ack_i,
    input  logic                gie_i,
    output logic [MW-1:0]       mode_lo_q,
    output logic [MW-1:0]       mode_hi_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] flag_q,
    output logic [NUM_PINS-1:0] irq_o
);

    logic [2*NUM_PINS-1:0] mode_all;
    logic [NUM_PINS-1:0]   cur, prv, level_req, clr;

    eisc_ctrl_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .mode_lo_we(mode_lo_we), .mode_lo_wdata(mode_lo_wdata),
        .mode_hi_we(mode_hi_we), .mode_hi_wdata(mode_hi_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .mode_lo(mode_lo_q), .mode_hi(mode_hi_q), .mask(mask_q)
    );

    assign mode_all = {mode_hi_q, mode_lo_q};

    // Per-pin clear request from the write-one strobe or the acknowledge.
    always_comb clr = ({NUM_PINS{flag_clr_we}} & flag_clr_data) | ack_i;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            eisc_sync_sample #(
                .SYNC_STAGES(SYNC_STAGES),
                .SAMPLE_STAGE(i >= HALF)
            ) i_samp (
                .clk(clk), .rst_n(rst_n), .pin_raw(pin_i[i]),
                .cur(cur[i]), .prv(prv[i])
            );
            eisc_flag_cell i_flag (
                .clk(clk), .rst_n(rst_n),
                .mode(sense_mode_e'(mode_all[2*i +: 2])),
                .cur(cur[i]), .prv(prv[i]), .clr(clr[i]),
                .flag(flag_q[i]), .level_req(level_req[i])
            );
        end
    endgenerate

    // Combine flag and level request, then gate by mask and global enable.
    always_comb irq_o = (flag_q | level_req) & mask_q & {NUM_PINS{gie_i}};

    AST_IRQ_NEEDS_GIE:  assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> gie_i); // R12
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~mask_q) == '0); // R12
    AST_ACK_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[0] && !(cur[0] ^ prv[0])) |=> !flag_q[0]); // R10

endmodule

// File: tb/test_ext_irq_sense_ctrl.sv
module test_ext_irq_sense_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'hFF;
    logic       mode_lo_we = 0, mode_hi_we = 0, mask_we = 0, flag_clr_we = 0;
    logic [7:0] mode_lo_wdata = 0, mode_hi_wdata = 0, mask_wdata = 0;
    logic [7:0] flag_clr_data = 0, ack_i = 0;
    logic       gie_i = 0;
    logic [7:0] mode_lo_q, mode_hi_q, mask_q, flag_q, irq_o;

    ext_irq_sense_ctrl i_ext_irq_sense_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .mode_lo_we(mode_lo_we), .mode_lo_wdata(mode_lo_wdata),
        .mode_hi_we(mode_hi_we), .mode_hi_wdata(mode_hi_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
        .ack_i(ack_i), .gie_i(gie_i),
        .mode_lo_q(mode_lo_q), .mode_hi_q(mode_hi_q), .mask_q(mask_q),
        .flag_q(flag_q), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    started = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [7:0] hq[$];
    logic [15:0] m_mode;
    logic [7:0] m_mask, m_flag;

    function automatic void fill_hist();
        hq.delete();
        for (int j = 0; j < 4; j++) hq.push_back(8'hFF);
    endfunction

    function automatic logic cur_of(int i);
        return (i >= 4) ? hq[hq.size()-3][i] : hq[hq.size()-2][i];
    endfunction

    function automatic logic prv_of(int i);
        return (i >= 4) ? hq[hq.size()-4][i] : hq[hq.size()-3][i];
    endfunction

    initial begin
        fill_hist();
        m_mode = 0; m_mask = 0; m_flag = 0;
    end

    // Model update on every rising edge, from pre-edge state and inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            fill_hist();
            m_mode = 0; m_mask = 0; m_flag = 0;
        end else begin
            logic [7:0] nf;
            nf = m_flag;
            for (int i = 0; i < 8; i++) begin
                logic c, p, ev;
                c = cur_of(i);
                p = prv_of(i);
                case (m_mode[2*i +: 2])
                    2'b01:   ev = c != p;
                    2'b10:   ev = p && !c;
                    2'b11:   ev = !p && c;
                    default: ev = 0;
                endcase
                if ((flag_clr_we && flag_clr_data[i]) || ack_i[i]) nf[i] = 0;
                if (ev) nf[i] = 1;
            end
            m_flag = nf;
            if (mode_lo_we) m_mode[7:0]  = mode_lo_wdata;
            if (mode_hi_we) m_mode[15:8] = mode_hi_wdata;
            if (mask_we)    m_mask       = mask_wdata;
            hq.push_back(pin_i);
            void'(hq.pop_front());
        end
        started = 1;
    end

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            logic [7:0] lvl;
            for (int i = 0; i < 8; i++)
                lvl[i] = (m_mode[2*i +: 2] == 2'b00) && !cur_of(i);
            check(cur_req, "flag_q", flag_q, m_flag);
            check(cur_req, "irq_o", irq_o, (m_flag | lvl) & m_mask & {8{gie_i}});
            check("R2", "mode_lo_q", mode_lo_q, m_mode[7:0]);
            check("R2", "mode_hi_q", mode_hi_q, m_mode[15:8]);
            check("R2", "mask_q", mask_q, m_mask);
        end
    end

    task automatic tick(int n);
        for (int j = 0; j < n; j++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic idle_strobes();
        mode_lo_we = 0; mode_hi_we = 0; mask_we = 0; flag_clr_we = 0; ack_i = 0;
    endtask

    task automatic set_modes(logic [7:0] lo, logic [7:0] hi);
        mode_lo_wdata = lo; mode_hi_wdata = hi;
        mode_lo_we = 1; mode_hi_we = 1;
        tick(1);
        idle_strobes();
    endtask

    task automatic clear_all();
        flag_clr_data = 8'hFF; flag_clr_we = 1;
        tick(1);
        idle_strobes();
    endtask

    task automatic random_pins(int n, int pulse_pct);
        for (int j = 0; j < n; j++) begin
            if (($urandom % 100) < pulse_pct) pin_i = pin_i ^ 8'(1 << ($urandom % 8));
            else if ($urandom % 4 == 0) pin_i = 8'($urandom);
            tick(1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(2);
        // R1: directed reset-state check.
        check("R1", "reset flags", flag_q, 8'h00);
        check("R1", "reset irq", irq_o, 8'h00);
        check("R1", "reset mode_hi", mode_hi_q, 8'h00);

        // R2: pin7 rise, pin6 fall, pin5 change, pin4 low; pin3 low, pin2 change, pin1 fall, pin0 rise.
        cur_req = "R2";
        set_modes(8'h1B, 8'hE4);
        check("R2", "mode_lo readback", mode_lo_q, 8'h1B);
        check("R2", "mode_hi readback", mode_hi_q, 8'hE4);
        mask_wdata = 8'hFF; mask_we = 1; gie_i = 1;
        tick(1);
        idle_strobes();

        // R3: exact latency for a falling edge on pin 6 (upper) and pin 1 (lower).
        cur_req = "R3";
        tick(4);
        pin_i = 8'hBD;            // pins 6 and 1 go low, first sampled at edge k
        tick(1);                  // now after edge k
        check("R3", "no flag yet", flag_q & 8'h42, 8'h00);
        tick(1);                  // after k+1
        check("R3", "lower group not yet", flag_q & 8'h02, 8'h00);
        tick(1);                  // after k+2
        check("R3", "lower group at k+2", flag_q & 8'h42, 8'h02);
        tick(1);                  // after k+3
        check("R3", "upper group at k+3", flag_q & 8'h42, 8'h42);
        pin_i = 8'hFF;
        tick(5);
        clear_all();

        // R4 R5 R6: random toggling under every mode arrangement, with clears.
        for (int rot = 0; rot < 4; rot++) begin
            cur_req = (rot == 0) ? "R4" : (rot == 1) ? "R5" : "R6";
            mask_wdata = 8'h00; mask_we = 1;
            tick(1);
            idle_strobes();
            set_modes(8'({8'h1B, 8'h1B} >> (2 * rot)), 8'({8'hE4, 8'hE4} >> (2 * rot)));
            clear_all();
            mask_wdata = 8'hFF; mask_we = 1;
            tick(1);
            idle_strobes();
            for (int b = 0; b < 40; b++) begin
                random_pins(8, 60);
                clear_all();
            end
        end

        // R6: single-cycle pulses in any-change mode on all pins.
        cur_req = "R6";
        set_modes(8'h55, 8'h55);
        pin_i = 8'hFF;
        tick(6);
        clear_all();
        tick(4);
        pin_i = 8'h00;
        tick(1);
        pin_i = 8'hFF;
        tick(5);
        check("R6", "pulse sets all", flag_q, 8'hFF);
        clear_all();

        // R7: level mode tracks low pins without latching.
        cur_req = "R7";
        set_modes(8'h00, 8'h00);
        clear_all();
        pin_i = 8'h0F;
        tick(6);
        check("R7", "level request", irq_o, 8'hF0);
        check("R7", "no level flag", flag_q, 8'h00);
        pin_i = 8'hFF;
        tick(6);
        check("R7", "level released", irq_o, 8'h00);

        // R8 R12: flags set while masked appear once enabled.
        cur_req = "R8";
        set_modes(8'hFF, 8'hFF);
        mask_wdata = 8'h00; mask_we = 1;
        tick(1);
        idle_strobes();
        pin_i = 8'h00;
        tick(2);
        pin_i = 8'hFF;
        tick(6);
        check("R8", "masked flags", flag_q, 8'hFF);
        check("R8", "masked irq", irq_o, 8'h00);
        cur_req = "R12";
        mask_wdata = 8'h3C; mask_we = 1;
        tick(1);
        idle_strobes();
        check("R12", "partial mask", irq_o, 8'h3C);
        gie_i = 0;
        tick(1);
        check("R12", "global off", irq_o, 8'h00);
        gie_i = 1;

        // R9: write-one-to-clear hits only selected bits.
        cur_req = "R9";
        flag_clr_data = 8'hA5; flag_clr_we = 1;
        tick(1);
        idle_strobes();
        check("R9", "partial clear", flag_q, 8'h5A);

        // R10: acknowledge clears its pin.
        cur_req = "R10";
        ack_i = 8'h42;
        tick(1);
        idle_strobes();
        check("R10", "ack clear", flag_q, 8'h18);
        clear_all();

        // R11: a clear landing with the set event leaves the flag set.
        cur_req = "R11";
        pin_i = 8'h00;
        tick(2);
        pin_i = 8'hFF;            // lower flags set at edge k+2, upper at k+3
        tick(2);                  // after edge k+1
        flag_clr_data = 8'h0F; flag_clr_we = 1;   // coincides with lower set at k+2
        tick(1);
        flag_clr_we = 0;
        ack_i = 8'hF0;                            // coincides with upper set at k+3
        tick(1);
        idle_strobes();
        check("R11", "set wins", flag_q, 8'hFF);
        clear_all();

        // R12: mixed random traffic with gie and mask toggling.
        cur_req = "R12";
        set_modes(8'h1B, 8'hE4);
        for (int b = 0; b < 60; b++) begin
            gie_i = 1'($urandom);
            mask_wdata = 8'($urandom); mask_we = 1;
            tick(1);
            idle_strobes();
            ack_i = 8'($urandom) & 8'($urandom);
            random_pins(6, 50);
        end

        tick(4);
        finish_run();
    end

endmodule